// File: doc/BRIEF.md
# Clock Generator Serial Configuration Slave

This block is the serial control port of a clock generator. A system controller writes and reads a small bank of 8-bit configuration bytes over a two-wire bus. Each configuration bit enables or stops one clock output. One bit also picks the role of a pin that serves either as a power-down input or as a reset output. The bus clock and data lines are sampled on the chip's system clock. The data line is driven only through a pull-low enable, so the pad behaves as an open drain.

After the device address, the controller sends a command byte. Its top bit picks single-byte access or block access, and its low seven bits give the starting register index. A block write carries a byte count ahead of its data. A block read returns the number of remaining registers ahead of the register contents. Block accesses walk upward from the starting index, and the controller may end them after any whole byte.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: The slave answers only to the 7-bit address 0x69 (address byte 0xD2 to write, 0xD3 to read). For any other address it does not acknowledge, and it keeps SDATA released until the next START.
- R2: The command byte uses bit 7 = 1 for single-byte access and bit 7 = 0 for block access, with bits 6:0 as the starting register index. An index at or above NUM_REGS (8) is not acknowledged.
- R3: In a byte write, the one data byte that follows the command is stored at the indexed register and acknowledged. Any further data byte is not acknowledged and is not stored.
- R4: In a byte read (write phase with the command, repeated START, then 0xD3), the slave returns the indexed register, MSB first. Any further bytes the master requests read as 0xFF.
- R5: In a block write, the byte after the command is a count. Data bytes are then stored at ascending indices. A byte past the count, or past the last register, is not acknowledged and is dropped.
- R6: A block read returns NUM_REGS minus the start index first, then the registers in ascending order, until the master answers with no-acknowledge.
- R7: A STOP returns the slave to idle at any bit position, and bytes already completed stay written. A later START begins a fresh transaction.
- R8: Reset loads every register with 0xFF, except register 6, which loads 0x7F.
- R9: The pin-mode output equals bit 7 of register 6. The value 0 (the reset value) selects reset-output mode and 1 selects power-down-input mode.
- R10: SDATA is pulled low only during an acknowledge bit the slave gives, or during a 0 bit of read data. Every byte goes MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial bus clock (asynchronous) |
| sda_i | input | 1 | Serial bus data as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDATA low (open-drain enable) |
| cfg_bytes_o | output | 64 | Register bank, register i at bits 8i+7:8i |
| pin_pd_mode_o | output | 1 | Shared pin mode: 1 power-down input, 0 reset output |

## Verification
The bench targets the points where the protocol is easy to get wrong. A block write that ignores its count would store the extra byte. A block that does not stop at the top of the bank would write past register 7. A block read that skips the count byte, or that reads from the index plus one, would return every byte shifted by one place. A command index out of range, a foreign address and a STOP in the middle of a byte are also driven. A design that acknowledges any of these, or that stays stuck in a partial byte, would show a low acknowledge or a corrupted next transaction. The pin-mode output is checked across a write that sets register 6 bit 7, because a design that takes the wrong bit would report the wrong mode.

// File: rtl/clkcfg_pkg.sv
// Shared types for the clock configuration serial slave.
// Assumes nothing beyond IEEE 1800-2017 enums.
package clkcfg_pkg;

    // Bit-level phase of the serial engine.
    typedef enum logic [2:0] {
        ST_IDLE,       // waiting for START
        ST_RX,         // shifting in a byte from the master
        ST_ACK_SETUP,  // byte received, wait for SCL low to drive ACK
        ST_ACK_HOLD,   // ACK bit on the wire, wait for SCL low to release
        ST_TX,         // shifting a byte out to the master
        ST_ACK_IN,     // sampling the master's ACK after a sent byte
        ST_IGNORE      // not addressed or refused, wait for START/STOP
    } ser_state_t;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_COUNT,
        K_DATA
    } byte_kind_t;

endpackage

// File: rtl/clkcfg_bus_sync.sv
// Brings SCL and SDA into the system clock domain through two flops each,
// then detects SCL edges and START/STOP conditions.
// Assumes the bus is much slower than clk (several clk cycles per SCL phase).
module clkcfg_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;

    // Synchronizer chains, idle-high at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Previous synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_evt = scl_s & scl_d & sda_d & ~sda_s;
        stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/clkcfg_regbank.sv
// Bank of NUM_REGS 8-bit configuration registers with one write port and
// one read port. Reads outside the bank return all-ones.
// Assumes the writer only issues in-range indices.
module clkcfg_regbank #(
    parameter int                    NUM_REGS    = 8,
    parameter int                    PW          = 4,
    parameter logic [NUM_REGS*8-1:0] RESET_VALUE = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [PW-1:0]         rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    logic [7:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // One register: default at reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= RESET_VALUE[i*8 +: 8];
            else if (wr_en && wr_idx == PW'(i))
                regs[i] <= wr_data;
        end
        assign cfg_o[i*8 +: 8] = regs[i];
    end

    // Read mux, all-ones outside the bank.
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == PW'(i)) rd_data = regs[i];
    end

    // R5
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < PW'(NUM_REGS)));

    // R3
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_o));

endmodule

// File: rtl/clkcfg_serial_fsm.sv
// Serial protocol engine: address match, command decode, byte and block
// writes and reads, ACK generation and open-drain data drive.
// Assumes synchronized bus signals and edge strobes from clkcfg_bus_sync.
module clkcfg_serial_fsm
    import clkcfg_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter int         PW       = 4,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic [7:0]    rd_data,
    output logic [PW-1:0] rd_idx,
    output logic          wr_en,
    output logic [PW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic          sda_oe
);
    ser_state_t state;
    byte_kind_t kind;
    logic [2:0]    bitcnt;
    logic [7:0]    shreg;
    logic [7:0]    txreg;
    logic          ack_flag;
    logic          next_tx;
    logic          byte_mode;
    logic          byte_done;
    logic          tx_is_count;
    logic          master_ack;
    logic [PW-1:0] ptr;
    logic [7:0]    wcount;

    logic [7:0]    rx_byte;
    logic          rx_done;
    logic          accept;
    logic [PW-1:0] ptr_inc;
    logic [7:0]    remain;
    logic [7:0]    next_tx_byte;

    // Byte assembly, pointer step and remaining-register count.
    always_comb begin
        rx_byte = {shreg[6:0], sda_s};
        rx_done = (state == ST_RX) && scl_rise && (bitcnt == 3'd7);
        ptr_inc = (ptr < PW'(NUM_REGS)) ? ptr + 1'b1 : ptr;
        remain  = 8'(NUM_REGS) - 8'(ptr);
    end

    // Acknowledge decision for the byte just completed.
    always_comb begin
        case (kind)
            K_ADDR:  accept = (rx_byte[7:1] == DEV_ADDR);
            K_CMD:   accept = ({1'b0, rx_byte[6:0]} < 8'(NUM_REGS));
            K_COUNT: accept = 1'b1;
            default: accept = (ptr < PW'(NUM_REGS)) &&
                              (byte_mode ? !byte_done : (wcount != 8'd0));
        endcase
    end

    // Register write strobe for accepted data bytes.
    always_comb begin
        wr_en   = rx_done && (kind == K_DATA) && accept;
        wr_idx  = ptr;
        wr_data = rx_byte;
    end

    // Read index: next register when continuing a block read.
    always_comb begin
        rd_idx = (state == ST_ACK_IN && !tx_is_count && !byte_mode) ? ptr_inc : ptr;
    end

    // Byte to send after a master ACK on a read.
    always_comb begin
        if (byte_mode) next_tx_byte = 8'hFF;
        else           next_tx_byte = rd_data;
    end

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            kind        <= K_ADDR;
            bitcnt      <= '0;
            shreg       <= '0;
            txreg       <= '0;
            ack_flag    <= 1'b0;
            next_tx     <= 1'b0;
            byte_mode   <= 1'b0;
            byte_done   <= 1'b0;
            tx_is_count <= 1'b0;
            master_ack  <= 1'b0;
            ptr         <= '0;
            wcount      <= '0;
            sda_oe      <= 1'b0;
        end else if (stop_evt) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (start_evt) begin
            state  <= ST_RX;
            kind   <= K_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg  <= rx_byte;
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            state    <= ST_ACK_SETUP;
                            ack_flag <= accept;
                            next_tx  <= 1'b0;
                            case (kind)
                                K_ADDR: begin
                                    next_tx <= rx_byte[0];
                                    if (!rx_byte[0]) kind <= K_CMD;
                                end
                                K_CMD: if (accept) begin
                                    byte_mode <= rx_byte[7];
                                    ptr       <= PW'(rx_byte[6:0]);
                                    byte_done <= 1'b0;
                                    kind      <= rx_byte[7] ? K_DATA : K_COUNT;
                                end
                                K_COUNT: begin
                                    wcount <= rx_byte;
                                    kind   <= K_DATA;
                                end
                                default: if (accept) begin
                                    ptr       <= ptr_inc;
                                    byte_done <= 1'b1;
                                    if (!byte_mode) wcount <= wcount - 8'd1;
                                end
                            endcase
                        end
                    end
                end
                ST_ACK_SETUP: begin
                    if (scl_fall) begin
                        sda_oe <= ack_flag;
                        state  <= ST_ACK_HOLD;
                    end
                end
                ST_ACK_HOLD: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (!ack_flag) begin
                            sda_oe <= 1'b0;
                            state  <= ST_IGNORE;
                        end else if (next_tx) begin
                            if (byte_mode) begin
                                txreg       <= rd_data;
                                sda_oe      <= ~rd_data[7];
                                byte_done   <= 1'b1;
                                tx_is_count <= 1'b0;
                            end else begin
                                txreg       <= remain;
                                sda_oe      <= ~remain[7];
                                tx_is_count <= 1'b1;
                            end
                            state <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_ACK_IN;
                        end else begin
                            txreg  <= {txreg[6:0], 1'b0};
                            sda_oe <= ~txreg[6];
                            bitcnt <= bitcnt + 3'd1;
                        end
                    end
                end
                ST_ACK_IN: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        if (master_ack) begin
                            if (!byte_mode && !tx_is_count) ptr <= ptr_inc;
                            tx_is_count <= 1'b0;
                            txreg       <= next_tx_byte;
                            sda_oe      <= ~next_tx_byte[7];
                            state       <= ST_TX;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R10
    sda_drive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ACK_HOLD || state == ST_TX));

    // R1
    ignore_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // R7
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE && !sda_oe));

    // R2
    ptr_in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_HOLD && kind == K_COUNT && ack_flag) |-> (ptr < PW'(NUM_REGS)));

endmodule

// File: rtl/clkcfg_serial_slave.sv
// Top of the clock generator serial configuration slave: synchronizer,
// protocol engine and register bank, plus the shared-pin mode bit.
// Assumes an external pull-up on SDATA; sda_pull_o = 1 pulls it low.
module clkcfg_serial_slave #(
    parameter int                    NUM_REGS    = 8,
    parameter logic [6:0]            DEV_ADDR    = 7'h69,
    parameter int                    PD_REG      = 6,
    parameter int                    PD_BIT      = 7,
    parameter logic [NUM_REGS*8-1:0] RESET_VALUE = 64'hFF7F_FFFF_FFFF_FFFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic [NUM_REGS*8-1:0] cfg_bytes_o,
    output logic                  pin_pd_mode_o
);
    localparam int PW = $clog2(NUM_REGS + 1);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic          wr_en;
    logic [PW-1:0] wr_idx, rd_idx;
    logic [7:0]    wr_data, rd_data;

    clkcfg_bus_sync #(.SYNC_STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    clkcfg_serial_fsm #(
        .NUM_REGS (NUM_REGS),
        .PW       (PW),
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_pull_o)
    );

    clkcfg_regbank #(
        .NUM_REGS    (NUM_REGS),
        .PW          (PW),
        .RESET_VALUE (RESET_VALUE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cfg_o   (cfg_bytes_o)
    );

    // Shared-pin mode taken from the selected register bit.
    assign pin_pd_mode_o = cfg_bytes_o[PD_REG*8 + PD_BIT];

    // R9
    mode_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !pin_pd_mode_o);

endmodule

// File: tb/clkcfg_serial_slave_test.sv
module clkcfg_serial_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        msda = 1'b1;
    logic        sda_line;
    logic        sda_pull;
    logic [63:0] cfg;
    logic        pd_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int    exp_q[$];
    string tag_q[$];
    int    act_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = msda & ~sda_pull;

    clkcfg_serial_slave uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl),
        .sda_i         (sda_line),
        .sda_pull_o    (sda_pull),
        .cfg_bytes_o   (cfg),
        .pin_pd_mode_o (pd_mode)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_item(input string tag, input int v);
        tag_q.push_back(tag);
        exp_q.push_back(v);
    endtask

    // Scoreboard monitor: pair each observed result with its expectation.
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                automatic int a = act_q.pop_front();
                automatic int e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, 64'(a), 64'(e));
            end
        end
    end

    task automatic bus_start();
        msda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
        msda = 1'b0; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        msda = 1'b0; wt(Q); scl = 1'b1; wt(Q); msda = 1'b1; wt(Q);
    endtask

    task automatic put_bit(input logic b);
        msda = b; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(Q);
    endtask

    // Master sends a byte; the slave's ACK level is pushed as a result.
    task automatic send_byte(input logic [7:0] b, input string tag, input int exp_ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        expect_item(tag, exp_ack);
        msda = 1'b1; wt(Q); scl = 1'b1; wt(Q/2);
        act_q.push_back(int'(sda_line));
        wt(Q/2); scl = 1'b0; wt(Q);
    endtask

    // Master reads a byte and answers with ack_lvl (0 = ACK).
    task automatic recv_byte(input logic ack_lvl, input string tag, input int exp_val);
        logic [7:0] v;
        v = '0;
        expect_item(tag, exp_val);
        msda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q); scl = 1'b1; wt(Q/2);
            v[i] = sda_line;
            wt(Q/2); scl = 1'b0;
        end
        act_q.push_back(int'(v));
        wt(2); msda = ack_lvl; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(Q);
        msda = 1'b1;
    endtask

    function automatic logic [7:0] reg_of(input int i);
        return cfg[i*8 +: 8];
    endfunction

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wt(5); rst_n = 1'b1; wt(5);

        // R8 reset values, R9 mode bit
        check("R8 reset bank", cfg, 64'hFF7F_FFFF_FFFF_FFFF);
        check("R9 reset pin mode", 64'(pd_mode), 64'd0);

        // R3 byte write to register 2, extra byte refused
        bus_start();
        send_byte(8'hD2, "R1 addr ack", 0);
        send_byte(8'h82, "R2 byte cmd ack", 0);
        send_byte(8'h5A, "R3 data ack", 0);
        send_byte(8'h33, "R3 extra nack", 1);
        bus_stop();
        check("R3 reg2 written", 64'(reg_of(2)), 64'h5A);
        check("R3 reg3 untouched", 64'(reg_of(3)), 64'hFF);

        // R4 byte read of register 2, second byte all-ones
        bus_start();
        send_byte(8'hD2, "R1 addr ack", 0);
        send_byte(8'h82, "R2 byte cmd ack", 0);
        bus_start();
        send_byte(8'hD3, "R1 read addr ack", 0);
        recv_byte(1'b0, "R4 byte read value", 'h5A);
        recv_byte(1'b1, "R4 byte read tail", 'hFF);
        bus_stop();

        // R5 block write at 4, count 3, fourth byte refused
        bus_start();
        send_byte(8'hD2, "R1 addr ack", 0);
        send_byte(8'h04, "R2 block cmd ack", 0);
        send_byte(8'h03, "R5 count ack", 0);
        send_byte(8'h11, "R5 data0 ack", 0);
        send_byte(8'h22, "R5 data1 ack", 0);
        send_byte(8'h33, "R5 data2 ack", 0);
        send_byte(8'h44, "R5 over count nack", 1);
        bus_stop();
        check("R5 block regs", 64'({reg_of(6), reg_of(5), reg_of(4)}), 64'h332211);
        check("R5 reg7 untouched", 64'(reg_of(7)), 64'hFF);
        check("R9 mode still reset", 64'(pd_mode), 64'd0);

        // R7 early stop inside block write; R9 mode flips
        bus_start();
        send_byte(8'hD2, "R1 addr ack", 0);
        send_byte(8'h06, "R2 block cmd ack", 0);
        send_byte(8'h02, "R5 count ack", 0);
        send_byte(8'hC5, "R7 first byte ack", 0);
        bus_stop();
        check("R7 reg6 kept", 64'(reg_of(6)), 64'hC5);
        check("R7 reg7 untouched", 64'(reg_of(7)), 64'hFF);
        check("R9 mode power-down", 64'(pd_mode), 64'd1);

        // R5 block write past the last register
        bus_start();
        send_byte(8'hD2, "R1 addr ack", 0);
        send_byte(8'h07, "R2 block cmd ack", 0);
        send_byte(8'h03, "R5 count ack", 0);
        send_byte(8'h77, "R5 last reg ack", 0);
        send_byte(8'h88, "R5 past end nack", 1);
        bus_stop();
        check("R5 reg7 written", 64'(reg_of(7)), 64'h77);

        // R6 block read from 5
        bus_start();
        send_byte(8'hD2, "R1 addr ack", 0);
        send_byte(8'h05, "R2 block cmd ack", 0);
        bus_start();
        send_byte(8'hD3, "R1 read addr ack", 0);
        recv_byte(1'b0, "R6 count", 3);
        recv_byte(1'b0, "R6 reg5", 'h22);
        recv_byte(1'b0, "R6 reg6", 'hC5);
        recv_byte(1'b1, "R6 reg7", 'h77);
        bus_stop();

        // R1 foreign address: no ACK, line stays released
        bus_start();
        send_byte(8'hA0, "R1 foreign nack", 1);
        send_byte(8'h00, "R1 stays released", 1);
        bus_stop();
        check("R1 bank unchanged", 64'(reg_of(0)), 64'hFF);

        // R2 command index out of range
        bus_start();
        send_byte(8'hD2, "R1 addr ack", 0);
        send_byte(8'h88, "R2 index 8 nack", 1);
        bus_stop();
        bus_start();
        send_byte(8'hD2, "R1 addr ack", 0);
        send_byte(8'h7F, "R2 index 127 nack", 1);
        bus_stop();

        // R7 STOP mid-byte, then a fresh byte write to register 0
        bus_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hD2, "R7 restart addr ack", 0);
        send_byte(8'h80, "R2 byte cmd ack", 0);
        send_byte(8'h3C, "R7 data ack", 0);
        bus_stop();
        check("R7 reg0 after restart", 64'(reg_of(0)), 64'h3C);

        // R6 block read from 0, R10 MSB-first of mixed bits
        bus_start();
        send_byte(8'hD2, "R1 addr ack", 0);
        send_byte(8'h00, "R2 block cmd ack", 0);
        bus_start();
        send_byte(8'hD3, "R1 read addr ack", 0);
        recv_byte(1'b0, "R6 count from 0", 8);
        recv_byte(1'b1, "R10 reg0 msb first", 'h3C);
        bus_stop();

        wt(20);
        check("R3 scoreboard drained", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule